// File: doc/BRIEF.md
# Two-Stage Serial Clock Prescaler

The block derives the shift timing of a half-duplex serial port from a fast functional clock. A first divider is shared by every chip select. It offers ratios of 2, 4, 7 or 10. Its output feeds a second divider of 2, 4 or 8, whose setting comes from the mode field of the chip select that is currently active. The overall serial clock period is therefore the product of the two ratios, and the longest period is 80 functional cycles.

The block has two outputs. The first is a single-cycle tick on every serial clock edge, which the shift engine uses to move data. The second is the serial clock level itself. A global enable gates the whole generator. A start strobe restarts both counters so that every transfer begins in phase. A polarity input selects whether the clock idles low or high.

The first-stage selection is global, so the controller must load it again whenever it activates a different chip select. The block keeps no copy of it per select.

Top module: `sclk_prescaler`

## Requirements
- R1: After reset, `edge_tick` is 0 and `sclk_out` equals `idle_high`.
- R2: While `gen_en` is 0, `edge_tick` stays 0 and `sclk_out` holds `idle_high`, and both counters are cleared. The first tick after re-enabling therefore arrives exactly one half serial period later.
- R3: The first-stage ratio N1 is set by `pre_sel`: 0 gives 2, 1 gives 4, 2 gives 7 and 3 gives 10.
- R4: The second-stage ratio N2 is set by `post_sel`: 0 gives 2, 1 gives 4 and 2 gives 8.
- R5: A `post_sel` value of 3 gives a second-stage ratio of 8, the same as encoding 2.
- R6: While enabled, `edge_tick` is high for exactly one cycle every N1*N2/2 cycles. `sclk_out` toggles in the same cycle in which the tick rises, and at no other time.
- R7: `idle_high` inverts `sclk_out`. With `idle_high` at 1, the clock idles high and its first edge after a start is falling.
- R8: A one-cycle `xfer_start` clears both counters and returns `sclk_out` to idle. The first tick then appears N1*N2/2 cycles after the clock edge that sampled the strobe.
- R9: The slowest setting (`pre_sel`=3, `post_sel`=2 or 3) gives a serial period of 80 cycles, which is 40 cycles between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_en | input | 1 | Global generator enable |
| pre_sel | input | 2 | First-stage ratio select (shared by all chip selects) |
| post_sel | input | 2 | Second-stage ratio field of the active chip select |
| idle_high | input | 1 | 1: the serial clock idles high |
| xfer_start | input | 1 | One-cycle strobe that restarts the counters for a new transfer |
| edge_tick | output | 1 | One-cycle pulse on every serial clock edge |
| sclk_out | output | 1 | Serial clock level |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `idle_high` changes only in cycles where the level check excuses it. The bench therefore changes the polarity and the ratio fields only in the same cycle as a start strobe or while the generator is disabled, and never in the middle of a running count. Apart from those moments the selects stay constant, so the tick spacing observed at the ports reflects a single ratio setting.

// File: rtl/sclk_pkg.sv
// Package: types and helpers shared by the prescaler modules.
// Assumes: second-stage codes saturate at the largest supported ratio.
package sclk_pkg;

    // Second-stage field encodings of a chip select's mode
    typedef enum logic [1:0] {
        POST_DIV2  = 2'd0,
        POST_DIV4  = 2'd1,
        POST_DIV8  = 2'd2,
        POST_ALT8  = 2'd3
    } post_code_t;

    // Largest of four ratio values; sizes the first-stage counter
    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sclk_pre_div.sv
// Module: first-stage divider. Counts functional cycles and pulses
// wrap_o on the last cycle of each group of (last_i + 1) cycles.
// Assumes: last_i changes only while clear_i is asserted; a larger
// count than last_i still wraps at once.
module sclk_pre_div #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic [CW-1:0] last_i,
    output logic          wrap_o
);
    logic [CW-1:0] cnt_q;
    logic          at_end;

    // Terminal count reached on this cycle
    always_comb at_end = (cnt_q >= last_i);

    // Pulse to the second stage on the final cycle of a group
    always_comb wrap_o = run_i && at_end;

    // Cycle counter, cleared on disable or restart
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            if (at_end) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sclk_post_div.sv
// Module: second-stage divider. Counts first-stage pulses and signals
// a serial clock edge after every (last_i + 1) of them.
// Assumes: last_i changes only while clear_i is asserted.
module sclk_post_div #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          step_i,
    input  logic [CW-1:0] last_i,
    output logic          edge_o
);
    logic [CW-1:0] cnt_q;
    logic          at_end;

    // Final pulse of a half serial period
    always_comb at_end = (cnt_q >= last_i);

    // Serial edge request on the final first-stage pulse
    always_comb edge_o = step_i && at_end;

    // Pulse counter, cleared on disable or restart
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            if (at_end) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sclk_level.sv
// Module: output stage. Registers the edge tick, toggles the clock
// phase on each edge and applies the idle polarity.
// Assumes: the phase returns to idle whenever clear_i is asserted.
module sclk_level (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic edge_i,
    input  logic idle_high,
    output logic tick_o,
    output logic sclk_o
);
    logic phase_q;

    // Tick register and clock phase toggle
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            tick_o  <= 1'b0;
            phase_q <= 1'b0;
        end else begin
            tick_o <= edge_i;
            if (edge_i) phase_q <= ~phase_q;
        end
    end

    // Polarity applied to the phase
    always_comb sclk_o = phase_q ^ idle_high;
endmodule

// File: rtl/sclk_prescaler.sv
// Module: two-stage serial clock prescaler (top). A shared first stage
// with four ratios feeds a per-select 2/4/8 second stage. The result
// drives a single-cycle edge tick and the serial clock level.
// Assumes: synchronous inputs; the selects are changed only during a
// start strobe or while disabled.
module sclk_prescaler #(
    parameter int unsigned PRE_R0      = 2,
    parameter int unsigned PRE_R1      = 4,
    parameter int unsigned PRE_R2      = 7,
    parameter int unsigned PRE_R3      = 10,
    parameter int unsigned POST_LOG2MX = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gen_en,
    input  logic [1:0] pre_sel,
    input  logic [1:0] post_sel,
    input  logic       idle_high,
    input  logic       xfer_start,
    output logic       edge_tick,
    output logic       sclk_out
);
    import sclk_pkg::*;

    localparam int unsigned PRE_MAX = max4(PRE_R0, PRE_R1, PRE_R2, PRE_R3);
    localparam int unsigned C1_W    = (PRE_MAX > 2) ? $clog2(PRE_MAX) : 1;
    localparam int unsigned C2_W    = (POST_LOG2MX > 1) ? POST_LOG2MX - 1 : 1;
    localparam int unsigned POST_MXC = POST_LOG2MX - 1;

    logic            clear, run;
    logic [C1_W-1:0] pre_last;
    logic [C2_W-1:0] post_last;
    logic            pre_wrap, post_edge;

    // Counters run when enabled and hold cleared on disable or restart
    always_comb begin
        clear = !gen_en || xfer_start;
        run   = gen_en && !xfer_start;
    end

    // First-stage terminal count from the shared select
    always_comb begin
        unique case (pre_sel)
            2'd0:    pre_last = C1_W'(PRE_R0 - 1);
            2'd1:    pre_last = C1_W'(PRE_R1 - 1);
            2'd2:    pre_last = C1_W'(PRE_R2 - 1);
            default: pre_last = C1_W'(PRE_R3 - 1);
        endcase
    end

    // Second-stage terminal count: half the ratio minus one, saturated
    always_comb begin
        int unsigned code;
        code = 32'(post_sel);
        if (code > POST_MXC) code = POST_MXC;
        post_last = C2_W'((1 << code) - 1);
    end

    sclk_pre_div #(.CW(C1_W)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .run_i   (run),
        .last_i  (pre_last),
        .wrap_o  (pre_wrap)
    );

    sclk_post_div #(.CW(C2_W)) i_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .step_i  (pre_wrap),
        .last_i  (post_last),
        .edge_o  (post_edge)
    );

    sclk_level i_lvl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .edge_i    (post_edge),
        .idle_high (idle_high),
        .tick_o    (edge_tick),
        .sclk_o    (sclk_out)
    );
endmodule

// File: rtl/sclk_prescaler_chk.sv
// Module: checker bound to the prescaler. Observes only the ports.
// Assumes: idle_high changes only together with a start or a disable.
module sclk_prescaler_chk #(
    parameter int unsigned HALF_MAX = 40
) (
    input logic clk,
    input logic rst_n,
    input logic gen_en,
    input logic xfer_start,
    input logic idle_high,
    input logic edge_tick,
    input logic sclk_out
);
    logic [7:0] gap_q;

    // Cycles since the last tick or restart
    always_ff @(posedge clk) begin
        if (!rst_n || !gen_en || xfer_start || edge_tick) gap_q <= '0;
        else if (gap_q != 8'hFF)                          gap_q <= gap_q + 1'b1;
    end

    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (!edge_tick && sclk_out == idle_high));

    // R6
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_tick |=> !edge_tick);

    // R6
    tick_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_tick && $stable(idle_high)) |-> (sclk_out != $past(sclk_out)));

    // R6
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_tick && $stable(idle_high) && $past(gen_en) && !$past(xfer_start))
            |-> $stable(sclk_out));

    // R8
    restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (!edge_tick && sclk_out == idle_high));

    // R9
    slow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= 8'(HALF_MAX));
endmodule

bind sclk_prescaler sclk_prescaler_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_en     (gen_en),
    .xfer_start (xfer_start),
    .idle_high  (idle_high),
    .edge_tick  (edge_tick),
    .sclk_out   (sclk_out)
);

// File: tb/test_sclk_prescaler.sv
module test_sclk_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_en = 1'b0;
    logic [1:0] pre_sel = 2'd0;
    logic [1:0] post_sel = 2'd0;
    logic       idle_high = 1'b0;
    logic       xfer_start = 1'b0;
    logic       edge_tick, sclk_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sclk_prescaler i_sclk_prescaler (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .pre_sel(pre_sel),
        .post_sel(post_sel), .idle_high(idle_high), .xfer_start(xfer_start),
        .edge_tick(edge_tick), .sclk_out(sclk_out)
    );

    function automatic int n1_of(input int s);
        case (s) 0: return 2; 1: return 4; 2: return 7; default: return 10; endcase
    endfunction

    function automatic int n2_of(input int s);
        case (s) 0: return 2; 1: return 4; default: return 8; endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Follow j cycles after a restart; compare tick and level each cycle
    task automatic follow(input int half, input int cycles, input bit inv,
                          input string req);
        int bad_t, bad_l, act, exp;
        bad_t = 0; bad_l = 0; act = 0; exp = 0;
        for (int j = 1; j <= cycles; j++) begin
            @(posedge clk); @(negedge clk);
            if ((edge_tick !== (j % half == 0)) && bad_t == 0) begin
                bad_t = j; act = edge_tick; exp = (j % half == 0);
            end
            if ((sclk_out !== (inv ^ ((j / half) % 2 == 1))) && bad_l == 0) begin
                bad_l = j;
            end
        end
        check(bad_t == 0, {req, " tick"}, act, exp);
        check(bad_l == 0, {req, " level"}, bad_l, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(edge_tick === 1'b0, "R1 tick", edge_tick, 0);
        check(sclk_out === 1'b0, "R1 sclk", sclk_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(edge_tick === 1'b0 && sclk_out === 1'b0, "R1 idle", sclk_out, 0);

        // R3 R4 R5 R6 R7 R8 R9: sweep all selects and polarities
        for (int inv = 0; inv < 2; inv++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    int half;
                    half = n1_of(a) * n2_of(b) / 2;
                    pre_sel = a[1:0]; post_sel = b[1:0]; idle_high = inv[0];
                    gen_en = 1'b1; xfer_start = 1'b1;
                    @(posedge clk); @(negedge clk);
                    xfer_start = 1'b0;
                    check(edge_tick === 1'b0 && sclk_out === inv[0],
                          "R8 restart idle", sclk_out, inv);
                    if (b == 3)       follow(half, 2 * half + 3, inv[0], "R5 sweep");
                    else if (a == 3 && b == 2) follow(half, 2 * half + 3, inv[0], "R9 slowest");
                    else if (inv == 1) follow(half, 2 * half + 3, inv[0], "R7 sweep");
                    else              follow(half, 2 * half + 3, inv[0], "R3 R4 R6 sweep");
                end
            end
        end

        // R2: disable mid-count, hold idle, then re-enable
        for (int inv = 0; inv < 2; inv++) begin
            int bad;
            bad = 0;
            pre_sel = 2'd1; post_sel = 2'd1; idle_high = inv[0];
            xfer_start = 1'b1; gen_en = 1'b1;
            @(posedge clk); @(negedge clk);
            xfer_start = 1'b0;
            repeat (11) begin @(posedge clk); @(negedge clk); end
            gen_en = 1'b0;
            for (int k = 0; k < 50; k++) begin
                @(posedge clk); @(negedge clk);
                if (edge_tick !== 1'b0 || sclk_out !== inv[0]) bad++;
            end
            check(bad == 0, "R2 disabled hold", bad, 0);
            gen_en = 1'b1;
            follow(8, 20, inv[0], "R2 re-enable");
        end

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule